// File: doc/BRIEF.md
# PLL Lock and Bandwidth-Mode Supervisor

This block is the digital watchdog beside a clock-multiplying PLL. It scales the oscillator clock down by a programmable reference ratio and scales the VCO clock down by a programmable even loop ratio. It then counts how many divided-VCO rising edges arrive during a measurement window of a fixed number of divided-reference periods. The gap between that count and the window length is the frequency error. The block compares frequency only and does not compare phase, so it reaches a decision once per window, and the decision rate follows the divided reference frequency.

From the error it keeps two status bits. The track bit says the VCO is close enough for the narrow, low-jitter filter bandwidth. The lock bit says the multiplied clock is safe to use as the system clock. In automatic mode the track bit selects the filter bandwidth directly. In manual mode a control input selects it. Each status bit has a sticky change flag that is cleared by writing 1 to it. Each change flag can raise the interrupt line when its enable bit is set, so software can either take the interrupt or poll the lock bit.

Top module: `pll_lock_supervisor`

## Requirements
- R1: The divided reference period is `ref_div + 1` oscillator cycles, for any `ref_div` from 0 to 63.
- R2: The divided VCO clock is a square wave whose period is `2 * (loop_div + 1)` VCO cycles, for any `loop_div` from 0 to 63.
- R3: A measurement window spans 16 divided-reference periods. Its frequency error is the absolute difference between the number of divided-VCO rising edges in the window and 16.
- R4: A window with an error of 2 or less sets `track`.
- R5: `locked` sets at the end of the second window in a row that has an error of 0. `locked` is never 1 while `track` is 0.
- R6: A window with an error greater than 4 clears both `track` and `locked`.
- R7: A window with an error of 3 or 4 leaves `track` and `locked` unchanged. Starting from acquisition, such windows never set `track`.
- R8: `narrow_bw` (1 = narrow tracking bandwidth, 0 = wide acquisition bandwidth) equals `track` when `auto_bw` is 1 and equals `manual_track` when `auto_bw` is 0.
- R9: `track_chg` and `lock_chg` set on any change of `track` or `locked` respectively. They clear on a cycle in which `clr_track_chg` or `clr_lock_chg` is 1. A set in the same cycle takes priority over the clear.
- R10: `irq` is 1 exactly when (`track_chg` and `track_ie`) or (`lock_chg` and `lock_ie`).
- R11: While reset is held and just after it is released, `track`, `locked`, `track_chg`, `lock_chg` and `irq` are 0, and the filter is in acquisition mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all status logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| clk_vco | input | 1 | VCO output clock |
| ref_div | input | 6 | Reference ratio minus one |
| loop_div | input | 6 | Half the loop ratio, minus one |
| auto_bw | input | 1 | 1 = detector selects the filter bandwidth |
| manual_track | input | 1 | Bandwidth choice used when auto_bw is 0 |
| track_ie | input | 1 | Interrupt enable for track_chg |
| lock_ie | input | 1 | Interrupt enable for lock_chg |
| clr_track_chg | input | 1 | Write-1 clear for track_chg |
| clr_lock_chg | input | 1 | Write-1 clear for lock_chg |
| track | output | 1 | Tracking status |
| locked | output | 1 | Lock status |
| narrow_bw | output | 1 | Filter bandwidth select |
| track_chg | output | 1 | Sticky track-change flag |
| lock_chg | output | 1 | Sticky lock-change flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the hysteresis band. An error of 3 or 4 must hold a lock that already exists, yet must not raise `track` from acquisition. The bench reaches the band by first locking on a matched VCO period. It then stretches the VCO period by 25 percent without a reset, which gives 12 or 13 edges per window. Later it enters the same band from below, after a 60 percent stretch. Expected flag values come from the nominal edge count `16 / factor`, with its floor and ceiling taken as the two possible counts. The bench sweeps many reference and loop ratios, including both extreme settings.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;
   localparam int CNT_W = 16;
   typedef logic [CNT_W-1:0] cnt_t;

   function automatic cnt_t abs_err(cnt_t a, cnt_t b);
      return (a > b) ? (a - b) : (b - a);
   endfunction
endpackage

// File: rtl/pll_ratio_div.sv
module pll_ratio_div #(
   parameter int W          = 6,
   parameter bit TOGGLE_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ratio_m1,
   output logic         div_out
);
   generate
      if (W < 1) begin : g_bad_width
         $error("pll_ratio_div: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;
   logic         wrap;

   assign wrap = (cnt >= ratio_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= wrap ? '0 : cnt + 1'b1;
   end

   generate
      if (TOGGLE_OUT) begin : g_toggle
         logic half_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    half_q <= 1'b0;
            else if (wrap) half_q <= ~half_q;
         end
         assign div_out = half_q;
      end else begin : g_pulse
         assign div_out = wrap;
      end
   endgenerate
endmodule

// File: rtl/pll_edge_sync.sv
module pll_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pll_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-1:0], async_in};
   end

   assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/pll_freq_window.sv
module pll_freq_window
   import pll_sup_pkg::*;
#(
   parameter int WIN_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   input  logic fb_rise,
   output logic meas_valid,
   output cnt_t meas_err
);
   localparam int WIN_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

   generate
      if (WIN_LEN < 2 || WIN_LEN >= (1 << (CNT_W - 1))) begin : g_bad_win
         $error("pll_freq_window: WIN_LEN out of range");
      end
   endgenerate

   logic [WIN_W-1:0] win_cnt;
   cnt_t             fb_cnt;
   cnt_t             fb_next;
   logic             win_last;

   assign fb_next  = (fb_rise && fb_cnt != '1) ? fb_cnt + 1'b1 : fb_cnt;
   assign win_last = ref_tick && (win_cnt == WIN_W'(WIN_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt    <= '0;
         fb_cnt     <= '0;
         meas_valid <= 1'b0;
         meas_err   <= '0;
      end else if (win_last) begin
         win_cnt    <= '0;
         fb_cnt     <= '0;
         meas_valid <= 1'b1;
         meas_err   <= abs_err(fb_next, cnt_t'(WIN_LEN));
      end else begin
         fb_cnt     <= fb_next;
         meas_valid <= 1'b0;
         if (ref_tick) win_cnt <= win_cnt + 1'b1;
      end
   end

   // R3: a result only follows a closing reference tick
   a_r3_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> $past(ref_tick));
   // R3: windows never close back to back
   a_r3_valid_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid);
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
   import pll_sup_pkg::*;
#(
   parameter int TRACK_TOL  = 2,
   parameter int UNLOCK_TOL = 4,
   parameter int LOCK_WINS  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic meas_valid,
   input  cnt_t meas_err,
   input  logic auto_bw,
   input  logic manual_track,
   input  logic track_ie,
   input  logic lock_ie,
   input  logic clr_track_chg,
   input  logic clr_lock_chg,
   output logic track,
   output logic locked,
   output logic narrow_bw,
   output logic track_chg,
   output logic lock_chg,
   output logic irq
);
   localparam int ZW = $clog2(LOCK_WINS + 1);

   generate
      if (TRACK_TOL >= UNLOCK_TOL) begin : g_bad_tol
         $error("pll_lock_ctrl: TRACK_TOL must be below UNLOCK_TOL");
      end
      if (LOCK_WINS < 1) begin : g_bad_wins
         $error("pll_lock_ctrl: LOCK_WINS must be at least 1");
      end
   endgenerate

   logic [ZW-1:0] zrun;
   logic          track_d, locked_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         track  <= 1'b0;
         locked <= 1'b0;
         zrun   <= '0;
      end else if (meas_valid) begin
         if (meas_err > cnt_t'(UNLOCK_TOL)) begin
            track  <= 1'b0;
            locked <= 1'b0;
            zrun   <= '0;
         end else begin
            if (meas_err <= cnt_t'(TRACK_TOL)) track <= 1'b1;
            if (meas_err == '0) begin
               if (zrun < ZW'(LOCK_WINS))      zrun   <= zrun + 1'b1;
               if (zrun >= ZW'(LOCK_WINS - 1)) locked <= 1'b1;
            end else begin
               zrun <= '0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         track_d   <= 1'b0;
         locked_d  <= 1'b0;
         track_chg <= 1'b0;
         lock_chg  <= 1'b0;
      end else begin
         track_d  <= track;
         locked_d <= locked;
         if (track != track_d)   track_chg <= 1'b1;
         else if (clr_track_chg) track_chg <= 1'b0;
         if (locked != locked_d) lock_chg  <= 1'b1;
         else if (clr_lock_chg)  lock_chg  <= 1'b0;
      end
   end

   assign narrow_bw = auto_bw ? track : manual_track;
   assign irq       = (track_chg & track_ie) | (lock_chg & lock_ie);

   a_r5_lock_needs_track: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> track);
   a_r5_lock_rises_on_result: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(meas_valid));
   a_r6_large_error_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && meas_err > cnt_t'(UNLOCK_TOL)) |=> (!track && !locked));
   a_r7_band_keeps_acq: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && !track && meas_err > cnt_t'(TRACK_TOL)) |=> !track);
   a_r9_track_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (track != $past(track)) |=> track_chg);
   a_r9_lock_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (locked != $past(locked)) |=> lock_chg);
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
   import pll_sup_pkg::*;
#(
   parameter int REF_W       = 6,
   parameter int LOOP_W      = 6,
   parameter int WIN_LEN     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TRACK_TOL   = 2,
   parameter int UNLOCK_TOL  = 4,
   parameter int LOCK_WINS   = 2
) (
   input  logic              clk_osc,
   input  logic              rst_n,
   input  logic              clk_vco,
   input  logic [REF_W-1:0]  ref_div,
   input  logic [LOOP_W-1:0] loop_div,
   input  logic              auto_bw,
   input  logic              manual_track,
   input  logic              track_ie,
   input  logic              lock_ie,
   input  logic              clr_track_chg,
   input  logic              clr_lock_chg,
   output logic              track,
   output logic              locked,
   output logic              narrow_bw,
   output logic              track_chg,
   output logic              lock_chg,
   output logic              irq
);
   logic ref_tick, fb_div, fb_rise, meas_valid;
   cnt_t meas_err;

   pll_ratio_div #(.W(REF_W), .TOGGLE_OUT(1'b0)) u_ref_div (
      .clk(clk_osc), .rst_n(rst_n), .ratio_m1(ref_div), .div_out(ref_tick));

   pll_ratio_div #(.W(LOOP_W), .TOGGLE_OUT(1'b1)) u_loop_div (
      .clk(clk_vco), .rst_n(rst_n), .ratio_m1(loop_div), .div_out(fb_div));

   pll_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
      .clk(clk_osc), .rst_n(rst_n), .async_in(fb_div), .rise(fb_rise));

   pll_freq_window #(.WIN_LEN(WIN_LEN)) u_window (
      .clk(clk_osc), .rst_n(rst_n), .ref_tick(ref_tick), .fb_rise(fb_rise),
      .meas_valid(meas_valid), .meas_err(meas_err));

   pll_lock_ctrl #(.TRACK_TOL(TRACK_TOL), .UNLOCK_TOL(UNLOCK_TOL),
                   .LOCK_WINS(LOCK_WINS)) u_ctrl (
      .clk(clk_osc), .rst_n(rst_n), .meas_valid(meas_valid), .meas_err(meas_err),
      .auto_bw(auto_bw), .manual_track(manual_track), .track_ie(track_ie),
      .lock_ie(lock_ie), .clr_track_chg(clr_track_chg), .clr_lock_chg(clr_lock_chg),
      .track(track), .locked(locked), .narrow_bw(narrow_bw),
      .track_chg(track_chg), .lock_chg(lock_chg), .irq(irq));
endmodule

// File: tb/test_pll_lock_supervisor.sv
`timescale 1ns/1ps
module test_pll_lock_supervisor;
   localparam int WIN = 16;

   logic clk = 1'b0, clk_vco = 1'b0, rst_n = 1'b0;
   logic [5:0] ref_div = 6'd3, loop_div = 6'd1;
   logic auto_bw = 1'b1, manual_track = 1'b0, track_ie = 1'b0, lock_ie = 1'b0;
   logic clr_track_chg = 1'b0, clr_lock_chg = 1'b0;
   logic track, locked, narrow_bw, track_chg, lock_chg, irq;
   real  vco_half = 2.5;
   int   tests = 0, fails = 0;

   pll_lock_supervisor i_pll_lock_supervisor (
      .clk_osc(clk), .rst_n(rst_n), .clk_vco(clk_vco), .ref_div(ref_div),
      .loop_div(loop_div), .auto_bw(auto_bw), .manual_track(manual_track),
      .track_ie(track_ie), .lock_ie(lock_ie), .clr_track_chg(clr_track_chg),
      .clr_lock_chg(clr_lock_chg), .track(track), .locked(locked),
      .narrow_bw(narrow_bw), .track_chg(track_chg), .lock_chg(lock_chg), .irq(irq));

   always #2.5 clk = ~clk;
   initial begin
      #0.3;
      forever #(vco_half) clk_vco = ~clk_vco;
   end

   task automatic check(string req, string what, logic act, logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic set_vco(int r, int l, real factor);
      ref_div  = 6'(r);
      loop_div = 6'(l);
      vco_half = factor * (r + 1) * 5.0 / (4.0 * (l + 1));
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_windows(int r, int n);
      repeat (n * WIN * (r + 1)) @(posedge clk);
      @(negedge clk);
   endtask

   // expected flags from acquisition, from the two possible edge counts
   task automatic expect_from_acq(real factor, output logic et, output logic el);
      real c;
      int  lo, hi, elo, ehi, emax;
      c   = WIN / factor;
      lo  = int'($floor(c));
      hi  = int'($ceil(c));
      elo = (lo > WIN) ? lo - WIN : WIN - lo;
      ehi = (hi > WIN) ? hi - WIN : WIN - hi;
      emax = (elo > ehi) ? elo : ehi;
      et = (emax <= 2);
      el = (emax == 0);
   endtask

   task automatic run_case(string req, int r, int l, real factor);
      logic et, el;
      set_vco(r, l, factor);
      do_reset();
      wait_windows(r, 6);
      expect_from_acq(factor, et, el);
      check(req, $sformatf("track r=%0d l=%0d f=%0.2f", r, l, factor), track, et);
      check(req, $sformatf("locked r=%0d l=%0d f=%0.2f", r, l, factor), locked, el);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int rv[5] = '{3, 5, 7, 11, 15};
      int lv[3] = '{0, 1, 3};

      // R11 reset state
      set_vco(3, 1, 1.0);
      #1;
      check("R11", "track in reset", track, 1'b0);
      check("R11", "narrow_bw in reset", narrow_bw, 1'b0);
      do_reset();
      @(negedge clk);
      check("R11", "locked after reset", locked, 1'b0);
      check("R11", "track_chg after reset", track_chg, 1'b0);
      check("R11", "lock_chg after reset", lock_chg, 1'b0);
      check("R11", "irq after reset", irq, 1'b0);

      // R1 R2 R3 R5: matched ratios lock; R6: 60% slow VCO stays in acquisition
      foreach (rv[i]) foreach (lv[j]) begin
         run_case("R1_R2_R5", rv[i], lv[j], 1.0);
         run_case("R3_R6", rv[i], lv[j], 1.6);
      end
      // R1 R2 boundary ratios: 64 and 128
      run_case("R1_R2", 63, 63, 1.0);
      run_case("R1_R2", 63, 31, 1.0);
      run_case("R1_R2", 63, 63, 2.0);
      // R4: small error tracks but does not lock
      run_case("R4", 3, 1, 1.1);
      run_case("R4", 7, 3, 0.9);
      // R7: error of 3..4 from acquisition does not track
      run_case("R7", 5, 1, 1.25);

      // R7 hysteresis with a held lock, then R6 drop, then band from below
      set_vco(3, 1, 1.0);
      do_reset();
      wait_windows(3, 6);
      check("R5", "locked before band", locked, 1'b1);
      // R9 R10 flags and interrupt gating
      check("R9", "track_chg after lock", track_chg, 1'b1);
      check("R9", "lock_chg after lock", lock_chg, 1'b1);
      check("R10", "irq with enables off", irq, 1'b0);
      lock_ie = 1'b1;
      @(negedge clk);
      check("R10", "irq with lock_ie", irq, 1'b1);
      clr_lock_chg = 1'b1;
      @(negedge clk);
      clr_lock_chg = 1'b0;
      check("R9", "lock_chg after clear", lock_chg, 1'b0);
      check("R9", "track_chg kept", track_chg, 1'b1);
      check("R10", "irq after lock clear", irq, 1'b0);
      track_ie = 1'b1;
      @(negedge clk);
      check("R10", "irq with track_ie", irq, 1'b1);
      clr_track_chg = 1'b1;
      @(negedge clk);
      clr_track_chg = 1'b0;
      check("R10", "irq after both cleared", irq, 1'b0);

      set_vco(3, 1, 1.25);
      wait_windows(3, 6);
      check("R7", "locked held in band", locked, 1'b1);
      check("R7", "track held in band", track, 1'b1);
      check("R9", "no change flag in band", lock_chg, 1'b0);
      set_vco(3, 1, 1.6);
      wait_windows(3, 6);
      check("R6", "track dropped", track, 1'b0);
      check("R6", "locked dropped", locked, 1'b0);
      check("R9", "lock_chg on drop", lock_chg, 1'b1);
      check("R10", "irq on drop", irq, 1'b1);
      set_vco(3, 1, 1.25);
      wait_windows(3, 6);
      check("R7", "no track from below", track, 1'b0);
      lock_ie = 1'b0; track_ie = 1'b0;

      // R8 manual and automatic bandwidth select
      auto_bw = 1'b0; manual_track = 1'b1;
      @(negedge clk);
      check("R8", "manual narrow in acquisition", narrow_bw, 1'b1);
      check("R8", "auto off: acquisition when not tracking", track, 1'b0);
      set_vco(3, 1, 1.0);
      wait_windows(3, 6);
      manual_track = 1'b0;
      @(negedge clk);
      check("R8", "manual wide while tracking", narrow_bw, 1'b0);
      check("R5", "lock works in manual mode", locked, 1'b1);
      auto_bw = 1'b1;
      @(negedge clk);
      check("R8", "auto follows track", narrow_bw, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule